// File: doc/BRIEF.md
# Address-Keyed Dependency Tracking Slice

This block is one slice of a distributed task-dependency tracker. Every task argument is a memory address with a direction (read-only or written). The slice keeps a set-associative table keyed by that address. Each live entry remembers whether a writer is pending on the address and holds a bounded list of task IDs that must wait until the address is released.

A new argument either opens a fresh entry or is checked against the entry that already exists. If the task has only one argument and its address is absent, the task goes straight to the ready output. In every other case the slice reports the task ID together with the number of waiting lists it joined in this slice. For an argument of this slice that cannot create a dependence, that number is zero. A finished argument releases every queued task ID, one per cycle, on the waiting output and then frees the entry.

When the addressed set has no free way, or the entry's waiting list is already full, the new argument is held back and is not accepted. Finished arguments always win arbitration, so held-back inserts can make progress once a release frees room.

Top module: `dst_slice`

## Requirements
- R1: After reset, no output pulse is present, neither input is acknowledged until the slice has selected it, and the table is empty, so the first argument to any address finds it absent.
- R2: A new argument with `new_single`=1 whose address is absent produces one `rdy_valid` pulse carrying its task ID, and no `cnt_valid` pulse.
- R3: A new argument with `new_single`=0 whose address is absent opens an entry and produces one `cnt_valid` pulse with `cnt_val`=0.
- R4: A read-only argument (`new_is_out`=0) to a present address with no pending writer gets `cnt_val`=0 and is not queued, so releasing that address emits nothing for it.
- R5: A written argument (`new_is_out`=1) to a present address, or any argument to an address that has a pending writer, gets `cnt_val`=1 and is appended to that address's waiting list.
- R6: A finished argument for a present address emits each queued task ID on `wait_valid` on consecutive cycles in the order they were queued, starting two cycles after its handshake, and then frees the entry so that the next access to that address counts 0.
- R7: A finished argument for an absent address is acknowledged and produces no output pulse.
- R8: A new argument to an absent address whose set has all ways in use is not acknowledged (`new_ready` stays 0) until a release frees a way in that set. In this build the set index is the low `log2(SETS)` bits of the address.
- R9: A new argument that would be appended to a waiting list already holding `KOL_DEPTH` IDs is not acknowledged until that list is released. No dependence is dropped.
- R10: When a new argument and a finished argument are both offered while the slice is idle, the finished argument is handshaken first.
- R11: At most one of `rdy_valid`, `cnt_valid` and `wait_valid` is high in any cycle, and each result is a single-cycle pulse.
- R12: The result pulse of a new argument appears in the cycle that immediately follows its handshake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| new_valid | input | 1 | A new argument is offered |
| new_ready | output | 1 | New argument accepted on this edge |
| new_addr | input | ADDR_W | Argument address |
| new_task | input | TASK_W | Owning task ID |
| new_is_out | input | 1 | 1 = argument is written, 0 = read-only |
| new_single | input | 1 | 1 = the task has exactly one argument |
| fin_valid | input | 1 | A finished argument is offered |
| fin_ready | output | 1 | Finished argument accepted on this edge |
| fin_addr | input | ADDR_W | Address being released |
| rdy_valid | output | 1 | Ready-task pulse |
| rdy_task | output | TASK_W | Ready task ID |
| cnt_valid | output | 1 | Dependence-count pulse |
| cnt_task | output | TASK_W | Task ID for the count |
| cnt_val | output | DCNT_W | Waiting lists joined in this slice |
| wait_valid | output | 1 | Released-waiter pulse |
| wait_task | output | TASK_W | Released task ID |

## Verification
A release and an insert can be offered in the same cycle, and the sharpest case is an insert that is already stalled on a full set while a release for that same set arrives. The bench fills one set and leaves a new argument pending on it. It then raises a finished argument for one of that set's entries while the insert is still offered. It judges the outcome by the cycle order of the two handshakes, by the waiter pulse arriving before the count pulse, and by the delayed insert landing as a fresh entry with a count of zero.

// File: rtl/dst_pkg.sv
// Package: shared types for the dependency slice.
// Assumes nothing beyond IEEE 1800-2017.
package dst_pkg;
    // Control state of the slice sequencer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_DRAIN = 2'd2
    } dst_state_e;
endpackage

// File: rtl/dst_lookup.sv
// Module: dst_lookup
// Compares a key against every way of one set.
// It returns the hit way and the lowest-numbered free way.
// Assumes WAY_W bits can encode WAYS-1 and that at most one way matches.
module dst_lookup #(
    parameter int ADDR_W = 16,
    parameter int WAYS   = 2,
    parameter int WAY_W  = 1
) (
    input  logic [WAYS-1:0]             way_vld,
    input  logic [WAYS-1:0][ADDR_W-1:0] way_addr,
    input  logic [ADDR_W-1:0]           key,
    output logic [WAYS-1:0]             match,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        has_free,
    output logic [WAY_W-1:0]            free_way
);
    // One comparator per way.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_vld[g] && (way_addr[g] == key);
    end

    // Encode the hit way and the lowest free way.
    always_comb begin
        hit      = |match;
        hit_way  = '0;
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
            if (!way_vld[w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/dst_dep_rule.sv
// Module: dst_dep_rule
// Decides whether a new argument joins a waiting list.
// It also decides whether the argument must be held back.
// Assumes the lookup result belongs to the set addressed by the argument.
module dst_dep_rule #(
    parameter int LEN_W     = 3,
    parameter int KOL_DEPTH = 4
) (
    input  logic             hit,
    input  logic             has_free,
    input  logic             is_out,
    input  logic             ent_wr,
    input  logic [LEN_W-1:0] ent_len,
    output logic             append,
    output logic             stall
);
    // A write, or any access behind a pending writer, must wait.
    // If the address is absent, a free way is needed instead.
    always_comb begin
        append = hit && (is_out || ent_wr);
        if (hit) stall = append && (ent_len == LEN_W'(KOL_DEPTH));
        else     stall = !has_free;
    end
endmodule

// File: rtl/dst_slice.sv
// Module: dst_slice
// One task-graph slice with a set-associative address table.
// Each entry holds a pending-writer flag and a bounded waiting list.
// Inserts report ready or a per-slice dependence count.
// Releases stream the waiting IDs out and then free the entry.
// Assumes SETS and WAYS are powers of two (at least 2) and KOL_DEPTH >= 2.
// A producer keeps its valid and data stable until ready is seen.
// A new argument may be withdrawn before it is accepted.
module dst_slice
    import dst_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int TASK_W    = 6,
    parameter int SETS      = 4,
    parameter int WAYS      = 2,
    parameter int KOL_DEPTH = 4,
    parameter int DCNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_valid,
    output logic              new_ready,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [TASK_W-1:0] new_task,
    input  logic              new_is_out,
    input  logic              new_single,
    input  logic              fin_valid,
    output logic              fin_ready,
    input  logic [ADDR_W-1:0] fin_addr,
    output logic              rdy_valid,
    output logic [TASK_W-1:0] rdy_task,
    output logic              cnt_valid,
    output logic [TASK_W-1:0] cnt_task,
    output logic [DCNT_W-1:0] cnt_val,
    output logic              wait_valid,
    output logic [TASK_W-1:0] wait_task
);
    localparam int SET_W     = $clog2(SETS);
    localparam int WAY_W     = $clog2(WAYS);
    localparam int ENT       = SETS * WAYS;
    localparam int ENT_W     = SET_W + WAY_W;
    localparam int LEN_W     = $clog2(KOL_DEPTH + 1);
    localparam int KOL_IDX_W = $clog2(KOL_DEPTH);

    // Table storage.
    logic              ent_vld [ENT];
    logic [ADDR_W-1:0] ent_addr[ENT];
    logic              ent_wr  [ENT];
    logic [LEN_W-1:0]  ent_len [ENT];
    logic [TASK_W-1:0] ent_kol [ENT][KOL_DEPTH];

    dst_state_e        state;
    logic              sel_fin;
    logic [ENT_W-1:0]  drain_ent;
    logic [LEN_W-1:0]  drain_idx;

    logic [ADDR_W-1:0]             key;
    logic [SET_W-1:0]              set_idx;
    logic [WAYS-1:0]               set_vld;
    logic [WAYS-1:0][ADDR_W-1:0]   set_addr;
    logic [WAYS-1:0]               match;
    logic                          hit, has_free, append, stall;
    logic [WAY_W-1:0]              hit_way, free_way;
    logic [ENT_W-1:0]              hit_ent, free_ent;

    // Pick the address to look up, then the set it indexes.
    assign key      = sel_fin ? fin_addr : new_addr;
    assign set_idx  = key[SET_W-1:0];
    assign hit_ent  = {set_idx, hit_way};
    assign free_ent = {set_idx, free_way};

    // Gather the ways of the addressed set.
    for (genvar g = 0; g < WAYS; g++) begin : g_set
        assign set_vld[g]  = ent_vld[{set_idx, WAY_W'(g)}];
        assign set_addr[g] = ent_addr[{set_idx, WAY_W'(g)}];
    end

    dst_lookup #(.ADDR_W(ADDR_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_lookup (
        .way_vld  (set_vld),
        .way_addr (set_addr),
        .key      (key),
        .match    (match),
        .hit      (hit),
        .hit_way  (hit_way),
        .has_free (has_free),
        .free_way (free_way)
    );

    dst_dep_rule #(.LEN_W(LEN_W), .KOL_DEPTH(KOL_DEPTH)) u_rule (
        .hit      (hit),
        .has_free (has_free),
        .is_out   (new_is_out),
        .ent_wr   (ent_wr[hit_ent]),
        .ent_len  (ent_len[hit_ent]),
        .append   (append),
        .stall    (stall)
    );

    // Accept only in the lookup state, and an insert only when it can finish.
    assign new_ready = (state == ST_LOOK) && !sel_fin && new_valid && !stall;
    assign fin_ready = (state == ST_LOOK) && sel_fin && fin_valid;

    // Sequencer, table update and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sel_fin    <= 1'b0;
            drain_ent  <= '0;
            drain_idx  <= '0;
            rdy_valid  <= 1'b0;
            rdy_task   <= '0;
            cnt_valid  <= 1'b0;
            cnt_task   <= '0;
            cnt_val    <= '0;
            wait_valid <= 1'b0;
            wait_task  <= '0;
            for (int e = 0; e < ENT; e++) begin
                ent_vld[e]  <= 1'b0;
                ent_addr[e] <= '0;
                ent_wr[e]   <= 1'b0;
                ent_len[e]  <= '0;
                for (int k = 0; k < KOL_DEPTH; k++) ent_kol[e][k] <= '0;
            end
        end else begin
            rdy_valid  <= 1'b0;
            cnt_valid  <= 1'b0;
            wait_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (fin_valid) begin
                        sel_fin <= 1'b1;
                        state   <= ST_LOOK;
                    end else if (new_valid) begin
                        sel_fin <= 1'b0;
                        state   <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    state <= ST_IDLE;
                    if (sel_fin) begin
                        if (fin_valid && hit) begin
                            drain_ent <= hit_ent;
                            drain_idx <= '0;
                            state     <= ST_DRAIN;
                        end
                    end else if (new_ready) begin
                        if (!hit) begin
                            ent_vld[free_ent]  <= 1'b1;
                            ent_addr[free_ent] <= new_addr;
                            ent_wr[free_ent]   <= new_is_out;
                            ent_len[free_ent]  <= '0;
                            if (new_single) begin
                                rdy_valid <= 1'b1;
                                rdy_task  <= new_task;
                            end else begin
                                cnt_valid <= 1'b1;
                                cnt_task  <= new_task;
                                cnt_val   <= '0;
                            end
                        end else begin
                            if (append) begin
                                ent_kol[hit_ent][ent_len[hit_ent][KOL_IDX_W-1:0]] <= new_task;
                                ent_len[hit_ent] <= ent_len[hit_ent] + 1'b1;
                                ent_wr[hit_ent]  <= ent_wr[hit_ent] | new_is_out;
                            end
                            cnt_valid <= 1'b1;
                            cnt_task  <= new_task;
                            cnt_val   <= {{(DCNT_W-1){1'b0}}, append};
                        end
                    end
                end
                ST_DRAIN: begin
                    if (drain_idx < ent_len[drain_ent]) begin
                        wait_valid <= 1'b1;
                        wait_task  <= ent_kol[drain_ent][drain_idx[KOL_IDX_W-1:0]];
                        drain_idx  <= drain_idx + 1'b1;
                    end else begin
                        ent_vld[drain_ent] <= 1'b0;
                        ent_len[drain_ent] <= '0;
                        state              <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: result pulses never overlap.
    a_r11_one_output: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rdy_valid, cnt_valid, wait_valid}));

    // R2: a ready pulse follows an accepted single-argument insert.
    a_r2_rdy_source: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |-> $past(new_valid && new_ready && new_single));

    // R12: a count pulse follows an accepted insert by one cycle.
    a_r12_cnt_source: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |-> $past(new_valid && new_ready));

    // R6: waiter pulses never come straight from an insert.
    a_r6_wait_source: assert property (@(posedge clk) disable iff (!rst_n)
        wait_valid |-> !$past(new_ready));

    // R10: a pending release is chosen over an insert.
    a_r10_fin_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fin_valid) |=> (sel_fin && state == ST_LOOK));

    // R9: a waiting list never grows past its depth.
    a_r9_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOK && hit) |-> (ent_len[hit_ent] <= LEN_W'(KOL_DEPTH)));

    // R8: an address is held in at most one way of its set.
    a_r8_unique_way: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOK) |-> ($countones(match) <= 1));
endmodule

// File: tb/sim_dst_slice.sv
// Directed bench for dst_slice: one task per scenario, each checking itself.
module sim_dst_slice;
    localparam int AW = 16;
    localparam int TW = 6;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          new_valid = 1'b0, new_is_out = 1'b0, new_single = 1'b0;
    logic [AW-1:0] new_addr = '0, fin_addr = '0;
    logic [TW-1:0] new_task = '0;
    logic          fin_valid = 1'b0;
    logic          new_ready, fin_ready;
    logic          rdy_valid, cnt_valid, wait_valid;
    logic [TW-1:0] rdy_task, cnt_task, wait_task;
    logic [CW-1:0] cnt_val;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // Event log filled by the monitor.
    int ev_n = 0;
    int ev_kind[64];
    int ev_task[64];
    int ev_val[64];
    int ev_cyc[64];

    dst_slice #(.ADDR_W(AW), .TASK_W(TW), .SETS(4), .WAYS(2),
                .KOL_DEPTH(4), .DCNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .new_valid(new_valid), .new_ready(new_ready), .new_addr(new_addr),
        .new_task(new_task), .new_is_out(new_is_out), .new_single(new_single),
        .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_addr(fin_addr),
        .rdy_valid(rdy_valid), .rdy_task(rdy_task),
        .cnt_valid(cnt_valid), .cnt_task(cnt_task), .cnt_val(cnt_val),
        .wait_valid(wait_valid), .wait_task(wait_task)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: log every output pulse away from the active edge.
    always @(negedge clk) begin
        if (rst_n && ev_n < 64) begin
            if (rdy_valid)  begin ev_kind[ev_n] = 1; ev_task[ev_n] = int'(rdy_task);  ev_val[ev_n] = 0;            ev_cyc[ev_n] = cyc; ev_n++; end
            if (cnt_valid)  begin ev_kind[ev_n] = 2; ev_task[ev_n] = int'(cnt_task);  ev_val[ev_n] = int'(cnt_val); ev_cyc[ev_n] = cyc; ev_n++; end
            if (wait_valid) begin ev_kind[ev_n] = 3; ev_task[ev_n] = int'(wait_task); ev_val[ev_n] = 0;            ev_cyc[ev_n] = cyc; ev_n++; end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Offer a new argument until it is accepted; hs = cycle of its result.
    task automatic send_new(input logic [AW-1:0] a, input int t, input bit wr,
                            input bit single, output int hs);
        int guard = 0;
        @(negedge clk);
        new_addr = a; new_task = TW'(t); new_is_out = wr; new_single = single;
        new_valid = 1'b1;
        hs = -1;
        while (hs < 0 && guard < 200) begin
            #1;
            if (new_ready) begin
                hs = cyc + 1;
                @(posedge clk); #1;
                new_valid = 1'b0;
            end else begin
                guard++;
                @(negedge clk);
            end
        end
        new_valid = 1'b0;
    endtask

    // Offer a finished argument until it is accepted; hs = handshake cycle.
    task automatic send_fin(input logic [AW-1:0] a, output int hs);
        int guard = 0;
        @(negedge clk);
        fin_addr = a; fin_valid = 1'b1;
        hs = -1;
        while (hs < 0 && guard < 200) begin
            #1;
            if (fin_ready) begin
                hs = cyc + 1;
                @(posedge clk); #1;
                fin_valid = 1'b0;
            end else begin
                guard++;
                @(negedge clk);
            end
        end
        fin_valid = 1'b0;
    endtask

    // Offer a new argument for n cycles and report whether it was ever accepted.
    task automatic offer_only(input logic [AW-1:0] a, input int t, input bit wr,
                              input int n, output bit seen);
        @(negedge clk);
        new_addr = a; new_task = TW'(t); new_is_out = wr; new_single = 1'b0;
        new_valid = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            #1;
            if (new_ready) seen = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1", "rdy_valid", int'(rdy_valid), 0);
        check("R1", "cnt_valid", int'(cnt_valid), 0);
        check("R1", "wait_valid", int'(wait_valid), 0);
        check("R1", "new_ready", int'(new_ready), 0);
        check("R1", "fin_ready", int'(fin_ready), 0);
    endtask

    task automatic t_single_ready();
        int hs;
        ev_n = 0;
        send_new(16'h0101, 5, 1'b0, 1'b1, hs);
        idle(4);
        check("R2", "event count", ev_n, 1);
        check("R2", "kind is ready", ev_kind[0], 1);
        check("R2", "ready task", ev_task[0], 5);
        check("R12", "result cycle", ev_cyc[0], hs);
    endtask

    task automatic t_writer_chain();
        int hs;
        ev_n = 0;
        send_new(16'h0202, 7, 1'b1, 1'b0, hs);
        idle(3);
        check("R3", "kind is count", ev_kind[0], 2);
        check("R3", "count value", ev_val[0], 0);
        check("R12", "count cycle", ev_cyc[0], hs);
        send_new(16'h0202, 8, 1'b0, 1'b0, hs);
        idle(3);
        check("R5", "reader after writer", ev_val[1], 1);
        send_new(16'h0202, 9, 1'b1, 1'b0, hs);
        idle(3);
        check("R5", "second writer", ev_val[2], 1);
        check("R5", "writer task", ev_task[2], 9);
        ev_n = 0;
        send_fin(16'h0202, hs);
        idle(6);
        check("R6", "waiters released", ev_n, 2);
        check("R6", "first waiter", ev_task[0], 8);
        check("R6", "second waiter", ev_task[1], 9);
        check("R6", "first waiter cycle", ev_cyc[0], hs + 1);
        check("R6", "consecutive", ev_cyc[1], ev_cyc[0] + 1);
        ev_n = 0;
        send_new(16'h0202, 10, 1'b0, 1'b0, hs);
        idle(3);
        check("R6", "entry freed", ev_val[0], 0);
        send_fin(16'h0202, hs);
        idle(5);
        check("R6", "nothing queued", ev_n, 1);
    endtask

    task automatic t_readers();
        int hs;
        ev_n = 0;
        send_new(16'h0303, 11, 1'b0, 1'b0, hs);
        send_new(16'h0303, 12, 1'b0, 1'b0, hs);
        idle(3);
        check("R4", "second reader count", ev_val[1], 0);
        send_fin(16'h0303, hs);
        idle(6);
        check("R4", "reader not queued", ev_n, 2);
    endtask

    task automatic t_absent_fin();
        int hs;
        ev_n = 0;
        send_fin(16'h0777, hs);
        idle(5);
        check("R7", "accepted", int'(hs >= 0), 1);
        check("R7", "no pulses", ev_n, 0);
    endtask

    task automatic t_list_full();
        int hs;
        bit seen;
        send_new(16'h0404, 20, 1'b1, 1'b0, hs);
        for (int t = 21; t <= 24; t++) send_new(16'h0404, t, 1'b1, 1'b0, hs);
        idle(3);
        offer_only(16'h0404, 25, 1'b1, 20, seen);
        new_valid = 1'b0;
        check("R9", "held back when list full", int'(seen), 0);
        ev_n = 0;
        send_fin(16'h0404, hs);
        idle(8);
        check("R9", "all four released", ev_n, 4);
        for (int i = 0; i < 4; i++) check("R9", "release order", ev_task[i], 21 + i);
        ev_n = 0;
        send_new(16'h0404, 25, 1'b1, 1'b0, hs);
        idle(3);
        check("R9", "retry accepted", ev_n, 1);
        check("R9", "retry count", ev_val[0], 0);
        send_fin(16'h0404, hs);
        idle(4);
    endtask

    task automatic t_set_full_collide();
        int hs;
        int fin_hs = -1;
        int new_hs = -1;
        bit seen;
        send_new(16'h0010, 30, 1'b1, 1'b0, hs);
        send_new(16'h0020, 31, 1'b1, 1'b0, hs);
        send_new(16'h0010, 32, 1'b1, 1'b0, hs);
        idle(3);
        offer_only(16'h0030, 33, 1'b1, 15, seen);
        check("R8", "held back on full set", int'(seen), 0);
        ev_n = 0;
        fin_addr = 16'h0010;
        fin_valid = 1'b1;
        for (int i = 0; i < 40 && new_hs < 0; i++) begin
            #1;
            if (fin_ready && fin_hs < 0) fin_hs = cyc + 1;
            if (new_ready && new_hs < 0) new_hs = cyc + 1;
            @(posedge clk); #1;
            if (fin_hs >= 0) fin_valid = 1'b0;
            if (new_hs >= 0) new_valid = 1'b0;
            @(negedge clk);
        end
        new_valid = 1'b0;
        fin_valid = 1'b0;
        idle(4);
        check("R10", "release taken", int'(fin_hs >= 0), 1);
        check("R10", "release first", int'(fin_hs >= 0 && fin_hs < new_hs), 1);
        check("R10", "waiter first", ev_kind[0], 3);
        check("R10", "waiter id", ev_task[0], 32);
        check("R8", "insert after free", ev_kind[1], 2);
        check("R8", "insert count", ev_val[1], 0);
        check("R8", "insert task", ev_task[1], 33);
        check("R11", "no overlap", int'(ev_cyc[0] != ev_cyc[1]), 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #500000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_single_ready();
        t_writer_chain();
        t_readers();
        t_absent_fin();
        t_list_full();
        t_set_full_collide();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule